// File: doc/BRIEF.md
# Float-to-Integer Converter

This block turns one IEEE-754 floating-point operand, single or double precision, into a signed two's-complement integer that is either 32 or 64 bits wide. The caller picks the rounding behaviour with a two-bit kind select: nearest-even, toward zero, toward plus infinity or toward minus infinity. Each kind carries its own fixed rounding direction, so the block needs no global rounding-mode input and has no effect on one. The same datapath serves all sixteen combinations of kind, source format and destination width. Subnormal operands are converted at their true value and are never flushed to zero.

Beside the integer, the block reports three cause flags: invalid, overflow and inexact. A NaN or infinite operand raises invalid. A finite operand whose rounded value does not fit the destination raises overflow. In either case the result is replaced by the largest positive integer of the destination width, whatever the sign of the operand. A conversion is presented with a valid strobe. Its result and flags are registered, and they appear one clock later together with an output valid.

Top module: `f2i_convert`

## Requirements
- R1: The kind select picks the rounding direction: 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward plus infinity and 3 rounds toward minus infinity.
- R2: With the source select at 1, the operand is a double taken from all 64 input bits. With it at 0, the operand is a single taken from bits 31:0, and bits 63:32 have no effect on the result or the flags.
- R3: With the destination select at 1, the result is a 64-bit two's-complement integer. With it at 0, bits 31:0 hold a 32-bit two's-complement integer and bits 63:32 are zero.
- R4: A NaN or infinite operand raises invalid, and the result is 0x7FFFFFFF for a 32-bit destination or 0x7FFFFFFFFFFFFFFF for a 64-bit destination.
- R5: A finite operand whose rounded value lies above 2^(N-1)-1 or below -2^(N-1), for destination width N, raises overflow and gives the same positive sentinel as R4, even for negative operands. The values -2^31 (32-bit) and -2^63 (64-bit) are in range.
- R6: Inexact is raised exactly when the rounded integer differs from the operand value and neither invalid nor overflow is raised.
- R7: Positive zero, negative zero and any value that rounds to zero give a result of 0 with invalid and overflow clear.
- R8: Subnormal operands are converted at their exact value. For example, the smallest positive subnormal gives 1 under kind 2 and 0 under kinds 0, 1 and 3, with inexact set in every case.
- R9: The result and flags of a conversion presented with in_valid high appear on the next clock edge, with out_valid high. In a cycle after in_valid was low, out_valid is low and the result and flags keep their previous values.
- R10: Synchronous active-high reset clears out_valid, the result and all three flags.
- R11: Invalid and overflow are never raised together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A conversion is presented this cycle |
| in_operand | input | 64 | Floating-point operand; single in bits 31:0 |
| in_src_dbl | input | 1 | 1 = double source, 0 = single source |
| in_dst_long | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| in_kind | input | 2 | Rounding kind, encoded as in R1 |
| out_valid | output | 1 | Result and flags below are new this cycle |
| out_result | output | 64 | Integer result or sentinel |
| out_invalid | output | 1 | Invalid cause |
| out_overflow | output | 1 | Overflow cause |
| out_inexact | output | 1 | Inexact cause |

## Verification
The properties assume that the select inputs and the operand are known (not X) whenever in_valid is high. They also assume that reset is held for at least one edge before the first conversion, so that the sentinel and hold checks compare against a defined previous result. The stimulus changes inputs only on the falling edge and always drives every select to a defined value together with the operand. It keeps in_valid low throughout reset, so every property sees only complete, well-formed conversions.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int OP_W    = 64;
    localparam int MANT_W  = 53;
    localparam int EXP_W   = 13;
    localparam int FRAC_W  = MANT_W + 1;
    localparam int EXT_W   = MANT_W + FRAC_W;
    localparam int MAG_W   = OP_W + 1;
    localparam int LSH_W   = 4;
    localparam int RSH_W   = 6;

    localparam logic signed [EXP_W-1:0] DBL_BIAS   = 13'sd1023;
    localparam logic signed [EXP_W-1:0] SGL_BIAS   = 13'sd127;
    localparam logic signed [EXP_W-1:0] INT_EXP    = 13'sd52;
    localparam logic signed [EXP_W-1:0] TOP_EXP    = 13'sd63;
    localparam logic signed [EXP_W-1:0] TINY_EXP   = -13'sd2;
    localparam logic [RSH_W-1:0]        RSH_MAX    = 6'd54;

    localparam logic [OP_W-1:0] SENT_WORD = 64'h0000_0000_7FFF_FFFF;
    localparam logic [OP_W-1:0] SENT_LONG = 64'h7FFF_FFFF_FFFF_FFFF;

    typedef enum logic [1:0] {
        KIND_NEAREST = 2'd0,
        KIND_TOZERO  = 2'd1,
        KIND_UP      = 2'd2,
        KIND_DOWN    = 2'd3
    } kind_e;

    // Operand in a common form: value = mant * 2^(exp - 52)
    typedef struct packed {
        logic                      sign;
        logic                      is_nan;
        logic                      is_inf;
        logic signed [EXP_W-1:0]   exp;
        logic [MANT_W-1:0]         mant;
    } unpacked_t;

    // Rounded magnitude with pass-through classification
    typedef struct packed {
        logic                      sign;
        logic                      is_nan;
        logic                      is_inf;
        logic                      huge;
        logic                      lost;
        logic [MAG_W-1:0]          mag;
    } rounded_t;

    function automatic logic [OP_W-1:0] sentinel(input logic dst_long);
        return dst_long ? SENT_LONG : SENT_WORD;
    endfunction

    function automatic logic [MAG_W-1:0] mag_limit(input logic dst_long, input logic neg);
        logic [MAG_W-1:0] lim;
        lim = dst_long ? (MAG_W'(1) << (OP_W - 1)) : (MAG_W'(1) << (OP_W/2 - 1));
        return neg ? lim : lim - MAG_W'(1);
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
(
    input  logic [OP_W-1:0] operand,
    input  logic            src_dbl,
    output unpacked_t       fields
);

    logic [10:0]             e_raw;
    logic [51:0]             f_raw;
    logic                    sgn;
    logic                    all_ones;
    logic                    zero_exp;
    logic signed [EXP_W-1:0] bias;

    always_comb begin
        if (src_dbl) begin
            e_raw    = operand[62:52];
            f_raw    = operand[51:0];
            sgn      = operand[63];
            all_ones = &operand[62:52];
            bias     = DBL_BIAS;
        end else begin
            e_raw    = {3'b000, operand[30:23]};
            f_raw    = {operand[22:0], 29'b0};
            sgn      = operand[31];
            all_ones = &operand[30:23];
            bias     = SGL_BIAS;
        end
        zero_exp      = (e_raw == 11'd0);
        fields.sign   = sgn;
        fields.is_nan = all_ones && (f_raw != 52'd0);
        fields.is_inf = all_ones && (f_raw == 52'd0);
        fields.mant   = {~zero_exp, f_raw};
        fields.exp    = zero_exp ? (13'sd1 - bias)
                                 : ($signed({2'b00, e_raw}) - bias);
    end

endmodule

// File: rtl/f2i_round.sv
module f2i_round
    import f2i_pkg::*;
(
    input  unpacked_t fields,
    input  kind_e     kind,
    output rounded_t  rnd
);

    logic              left_path;
    logic              huge;
    logic [RSH_W-1:0]  rsh;
    logic [LSH_W-1:0]  lsh;
    logic [EXT_W-1:0]  ext;
    logic [MAG_W-1:0]  int_part;
    logic              half;
    logic              sticky;
    logic              lost;
    logic              inc;

    always_comb begin
        left_path = (fields.exp >= INT_EXP);
        huge      = (fields.exp > TOP_EXP);

        if (fields.exp <= TINY_EXP)
            rsh = RSH_MAX;
        else if (left_path)
            rsh = '0;
        else
            rsh = RSH_W'(INT_EXP - fields.exp);

        lsh = (left_path && !huge) ? LSH_W'(fields.exp - INT_EXP) : '0;
        ext = {fields.mant, FRAC_W'(0)} >> rsh;

        if (left_path) begin
            int_part = MAG_W'(fields.mant) << lsh;
            half     = 1'b0;
            sticky   = 1'b0;
        end else begin
            int_part = MAG_W'(ext[EXT_W-1:FRAC_W]);
            half     = ext[FRAC_W-1];
            sticky   = |ext[FRAC_W-2:0];
        end
        lost = half | sticky;

        case (kind)
            KIND_NEAREST: inc = half & (sticky | int_part[0]);
            KIND_TOZERO:  inc = 1'b0;
            KIND_UP:      inc = lost & ~fields.sign;
            default:      inc = lost & fields.sign;
        endcase

        rnd.sign   = fields.sign;
        rnd.is_nan = fields.is_nan;
        rnd.is_inf = fields.is_inf;
        rnd.huge   = huge;
        rnd.lost   = lost;
        rnd.mag    = int_part + MAG_W'(inc);
    end

endmodule

// File: rtl/f2i_range.sv
module f2i_range
    import f2i_pkg::*;
(
    input  rounded_t        rnd,
    input  logic            dst_long,
    output logic [OP_W-1:0] value,
    output logic            invalid,
    output logic            overflow,
    output logic            inexact
);

    logic [OP_W-1:0] twos;

    always_comb begin
        invalid  = rnd.is_nan | rnd.is_inf;
        overflow = !invalid && (rnd.huge || (rnd.mag > mag_limit(dst_long, rnd.sign)));
        inexact  = !invalid && !overflow && rnd.lost;
        twos     = rnd.sign ? (~rnd.mag[OP_W-1:0] + OP_W'(1)) : rnd.mag[OP_W-1:0];

        if (invalid || overflow)
            value = sentinel(dst_long);
        else if (dst_long)
            value = twos;
        else
            value = {{(OP_W/2){1'b0}}, twos[OP_W/2-1:0]};
    end

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [63:0]     in_operand,
    input  logic            in_src_dbl,
    input  logic            in_dst_long,
    input  logic [1:0]      in_kind,
    output logic            out_valid,
    output logic [63:0]     out_result,
    output logic            out_invalid,
    output logic            out_overflow,
    output logic            out_inexact
);

    unpacked_t       fields;
    rounded_t        rnd;
    logic [OP_W-1:0] value;
    logic            inv_c;
    logic            ovf_c;
    logic            inx_c;

    f2i_unpack u_unpack (
        .operand (in_operand),
        .src_dbl (in_src_dbl),
        .fields  (fields)
    );

    f2i_round u_round (
        .fields (fields),
        .kind   (kind_e'(in_kind)),
        .rnd    (rnd)
    );

    f2i_range u_range (
        .rnd      (rnd),
        .dst_long (in_dst_long),
        .value    (value),
        .invalid  (inv_c),
        .overflow (ovf_c),
        .inexact  (inx_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_result   <= '0;
            out_invalid  <= 1'b0;
            out_overflow <= 1'b0;
            out_inexact  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result   <= value;
                out_invalid  <= inv_c;
                out_overflow <= ovf_c;
                out_inexact  <= inx_c;
            end
        end
    end

endmodule

// File: rtl/f2i_convert_chk.sv
module f2i_convert_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_operand,
    input logic        in_src_dbl,
    input logic        in_dst_long,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic        out_invalid,
    input logic        out_overflow,
    input logic        out_inexact
);

    logic special_in;
    assign special_in = in_src_dbl ? (&in_operand[62:52]) : (&in_operand[30:23]);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_result)));  // R9

    AST_SPECIAL_INVALID: assert property (@(posedge clk) disable iff (rst)
        (in_valid && special_in) |=> (out_invalid && !out_inexact));  // R4

    AST_LONG_SENTINEL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_dst_long) |=>
            (!(out_invalid || out_overflow) || out_result == 64'h7FFF_FFFF_FFFF_FFFF));  // R5

    AST_WORD_SENTINEL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dst_long) |=>
            (!(out_invalid || out_overflow) || out_result == 64'h0000_0000_7FFF_FFFF));  // R5

    AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_dst_long) |=> (out_result[63:32] == 32'd0));  // R3

    AST_CAUSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_invalid && out_overflow));  // R11

    AST_INEXACT_ALONE: assert property (@(posedge clk) disable iff (rst)
        out_inexact |-> (!out_invalid && !out_overflow));  // R6

endmodule

bind f2i_convert f2i_convert_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_operand   (in_operand),
    .in_src_dbl   (in_src_dbl),
    .in_dst_long  (in_dst_long),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_invalid  (out_invalid),
    .out_overflow (out_overflow),
    .out_inexact  (out_inexact)
);

// File: tb/sim_f2i_convert.sv
module sim_f2i_convert;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [63:0] in_operand;
    logic        in_src_dbl;
    logic        in_dst_long;
    logic [1:0]  in_kind;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;
    logic        out_overflow;
    logic        out_inexact;

    int errs  = 0;
    int total = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    f2i_convert u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_src_dbl(in_src_dbl), .in_dst_long(in_dst_long), .in_kind(in_kind),
        .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
        .out_overflow(out_overflow), .out_inexact(out_inexact)
    );

    typedef struct packed {
        logic        dbl;
        logic [63:0] bits;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 64'h4004_0000_0000_0000},  //  2.5
        '{1'b1, 64'hC004_0000_0000_0000},  // -2.5
        '{1'b1, 64'h400C_0000_0000_0000},  //  3.5
        '{1'b1, 64'h3FE0_0000_0000_0000},  //  0.5
        '{1'b1, 64'hBFD3_3333_3333_3333},  // -0.3
        '{1'b1, 64'h8000_0000_0000_0000},  // -0.0
        '{1'b1, 64'h41E0_0000_0000_0000},  //  2^31
        '{1'b1, 64'hC1E0_0000_0000_0000},  // -2^31
        '{1'b1, 64'h41DF_FFFF_FFE0_0000},  //  2^31 - 0.5
        '{1'b1, 64'hC1E0_0000_0010_0000},  // -2^31 - 0.5
        '{1'b1, 64'h43E0_0000_0000_0000},  //  2^63
        '{1'b1, 64'hC3E0_0000_0000_0000},  // -2^63
        '{1'b1, 64'h43DF_FFFF_FFFF_FFFF},  //  largest below 2^63
        '{1'b1, 64'h7FF0_0000_0000_0000},  // +inf
        '{1'b1, 64'h7FF8_0000_0000_0000},  //  NaN
        '{1'b1, 64'hFFF0_0000_0000_0000},  // -inf
        '{1'b1, 64'h0000_0000_0000_0001},  //  min subnormal
        '{1'b1, 64'h8000_0000_0000_0001},  // -min subnormal
        '{1'b1, 64'h4415_AF1D_78B5_8C40},  //  1e20
        '{1'b1, 64'h3FFC_0000_0000_0000},  //  1.75
        '{1'b1, 64'hBFFC_0000_0000_0000},  // -1.75
        '{1'b0, 64'hDEAD_BEEF_4020_0000},  //  2.5f, junk upper bits
        '{1'b0, 64'h0000_0000_C020_0000},  // -2.5f
        '{1'b0, 64'hFFFF_FFFF_4F00_0000},  //  2^31 f
        '{1'b0, 64'h1234_5678_CF00_0000},  // -2^31 f
        '{1'b0, 64'h0000_0000_5F00_0000},  //  2^63 f
        '{1'b0, 64'hA5A5_A5A5_DF00_0000},  // -2^63 f
        '{1'b0, 64'h0000_0000_0000_0001},  //  min subnormal f
        '{1'b0, 64'h0000_0000_7FC0_0000},  //  NaN f
        '{1'b0, 64'h5555_5555_FF80_0000},  // -inf f
        '{1'b0, 64'h0000_0000_3F00_0000},  //  0.5f
        '{1'b0, 64'h0000_0000_3FC0_0000},  //  1.5f
        '{1'b0, 64'h0000_0000_4EFF_FFFF},  //  largest f below 2^31
        '{1'b0, 64'hFFFF_0000_8000_0000}   // -0.0f
    };

    function automatic real op_value(input logic dbl, input logic [63:0] b);
        real m;
        int  e;
        if (dbl) return $bitstoreal(b);
        e = int'(b[30:23]);
        m = real'(b[22:0]);
        if (e == 0) m = m * (2.0 ** (-149.0));
        else        m = (m + 8388608.0) * (2.0 ** real'(e - 150));
        return b[31] ? -m : m;
    endfunction

    task automatic model(input logic dbl, input logic [63:0] b, input int kind,
                         input logic dl, output logic [63:0] res,
                         output logic inv, output logic ovf, output logic inx);
        real x, r, fl, d, hi;
        longint li;
        inv = dbl ? (&b[62:52]) : (&b[30:23]);
        ovf = 1'b0;
        inx = 1'b0;
        res = 64'd0;
        if (!inv) begin
            x  = op_value(dbl, b);
            fl = $floor(x);
            case (kind)
                0: begin
                    d = x - fl;
                    if (d > 0.5)      r = fl + 1.0;
                    else if (d < 0.5) r = fl;
                    else if ($floor(fl / 2.0) * 2.0 == fl) r = fl;
                    else              r = fl + 1.0;
                end
                1:       r = (x < 0.0) ? $ceil(x) : fl;
                2:       r = $ceil(x);
                default: r = fl;
            endcase
            hi  = dl ? 9223372036854775808.0 : 2147483648.0;
            ovf = (r >= hi) || (r < -hi);
            inx = !ovf && (r != x);
            if (!ovf) begin
                li  = longint'(r);
                res = dl ? li : {32'h0, li[31:0]};
            end
        end
        if (inv || ovf) res = dl ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
    endtask

    task automatic check64(input string req, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic check1(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Present one conversion; on return the registered outputs are valid.
    task automatic convert(input logic dbl, input logic [63:0] b,
                           input logic [1:0] kind, input logic dl);
        @(negedge clk);
        in_valid    = 1'b1;
        in_operand  = b;
        in_src_dbl  = dbl;
        in_dst_long = dl;
        in_kind     = kind;
        @(negedge clk);
        in_valid    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++;
            total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, total);
            $finish;
        end
    end

    initial begin
        logic [63:0] er, held;
        logic        ei, eo, ex;
        string       tag;

        rst = 1'b1; in_valid = 1'b0; in_operand = '0;
        in_src_dbl = 1'b0; in_dst_long = 1'b0; in_kind = 2'd0;
        repeat (3) @(negedge clk);
        // R10: reset state
        check1 ("R10", out_valid, 1'b0);
        check64("R10", out_result, 64'd0);
        check1 ("R10", out_invalid | out_overflow | out_inexact, 1'b0);
        rst = 1'b0;

        // Table walk against the real-number model
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < 4; k++) begin
                for (int w = 0; w < 2; w++) begin
                    convert(VECS[i].dbl, VECS[i].bits, 2'(k), w[0]);
                    model(VECS[i].dbl, VECS[i].bits, k, w[0], er, ei, eo, ex);
                    tag = ei ? "R4" : (eo ? "R5" : (VECS[i].dbl ? "R1" : "R2"));
                    check64(tag, out_result, er);
                    check1 ("R4", out_invalid, ei);
                    check1 ("R5", out_overflow, eo);
                    check1 ("R6", out_inexact, ex);
                    check1 ("R11", out_invalid & out_overflow, 1'b0);
                    check1 ("R9", out_valid, 1'b1);
                end
            end
        end

        // R1: ties to even, directed
        convert(1'b1, 64'h4004_0000_0000_0000, 2'd0, 1'b0);
        check64("R1", out_result, 64'd2);
        convert(1'b1, 64'h400C_0000_0000_0000, 2'd0, 1'b1);
        check64("R1", out_result, 64'd4);
        // R3: negative word result, upper half zero
        convert(1'b1, 64'hC004_0000_0000_0000, 2'd1, 1'b0);
        check64("R3", out_result, 64'h0000_0000_FFFF_FFFE);
        convert(1'b1, 64'hC004_0000_0000_0000, 2'd1, 1'b1);
        check64("R3", out_result, 64'hFFFF_FFFF_FFFF_FFFE);
        // R2: upper junk ignored for single source
        convert(1'b0, 64'hFFFF_FFFF_3FC0_0000, 2'd2, 1'b1);
        check64("R2", out_result, 64'd2);
        check1 ("R2", out_inexact, 1'b1);
        // R4: NaN single into long
        convert(1'b0, 64'h0000_0000_7FC0_0000, 2'd3, 1'b1);
        check64("R4", out_result, 64'h7FFF_FFFF_FFFF_FFFF);
        check1 ("R4", out_invalid, 1'b1);
        // R5: negative overflow gives the positive sentinel; -2^31 word fits
        convert(1'b1, 64'hC415_AF1D_78B5_8C40, 2'd3, 1'b0);
        check64("R5", out_result, 64'h0000_0000_7FFF_FFFF);
        check1 ("R5", out_overflow, 1'b1);
        convert(1'b1, 64'hC1E0_0000_0000_0000, 2'd1, 1'b0);
        check64("R5", out_result, 64'h0000_0000_8000_0000);
        check1 ("R5", out_overflow, 1'b0);
        convert(1'b1, 64'hC3E0_0000_0000_0000, 2'd0, 1'b1);
        check64("R5", out_result, 64'h8000_0000_0000_0000);
        check1 ("R5", out_overflow, 1'b0);
        // R7: negative zero and round-to-zero
        convert(1'b1, 64'h8000_0000_0000_0000, 2'd3, 1'b1);
        check64("R7", out_result, 64'd0);
        check1 ("R7", out_invalid | out_overflow | out_inexact, 1'b0);
        convert(1'b1, 64'hBFD3_3333_3333_3333, 2'd2, 1'b0);
        check64("R7", out_result, 64'd0);
        check1 ("R7", out_invalid | out_overflow, 1'b0);
        // R8: subnormals not flushed
        convert(1'b1, 64'h0000_0000_0000_0001, 2'd2, 1'b1);
        check64("R8", out_result, 64'd1);
        check1 ("R8", out_inexact, 1'b1);
        convert(1'b1, 64'h8000_0000_0000_0001, 2'd3, 1'b1);
        check64("R8", out_result, 64'hFFFF_FFFF_FFFF_FFFF);
        // R6: exact integer raises no inexact
        convert(1'b1, 64'h41E0_0000_0000_0000, 2'd0, 1'b1);
        check1 ("R6", out_inexact, 1'b0);
        check64("R6", out_result, 64'h0000_0000_8000_0000);
        // R9: idle cycle holds result and drops valid
        held = out_result;
        in_operand = 64'h4415_AF1D_78B5_8C40;
        in_kind    = 2'd2;
        @(negedge clk);
        check1 ("R9", out_valid, 1'b0);
        check64("R9", out_result, held);
        check1 ("R9", out_overflow, 1'b0);
        // R10: reset after activity
        convert(1'b1, 64'h7FF0_0000_0000_0000, 2'd0, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check64("R10", out_result, 64'd0);
        check1 ("R10", out_invalid, 1'b0);
        rst = 1'b0;

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, total);
        $finish;
    end

endmodule